// File: doc/BRIEF.md
# 64-bit Multiply-Accumulate Unit

This unit multiplies two 32-bit operands into a 64-bit product over a fixed number of clock cycles. A single mode bit selects whether the operands are two's complement or unsigned. A second mode bit adds a 64-bit value, supplied as separate high and low words, to the product. The sum wraps modulo 2^64. A third mode bit asks the unit to report negative and zero flags, which are computed over the whole 64-bit result.

The unit also splits an instruction word into the four 4-bit register indices that a surrounding datapath needs for this operation: two destinations (high and low result) and two sources (multiplier and multiplicand). Operand values, the accumulator words and the mode bits are captured in the cycle that starts the operation. The result is presented with a one-cycle done pulse and holds until the next operation finishes.

Top module: `mac64_unit`

## Requirements
- R1: After reset, res_hi, res_lo, flag_n, flag_z, flag_vld and done are all 0.
- R2: The index outputs are combinational slices of instr_word: idx_dst_hi = bits 19:16, idx_dst_lo = bits 15:12, idx_mplier = bits 11:8, idx_mcand = bits 3:0.
- R3: With mode_signed = 0, both operands are zero-extended to 64 bits, and the product is their unsigned 64-bit product.
- R4: With mode_signed = 1, both operands are sign-extended as two's complement, and the result is the signed 64-bit product.
- R5: With mode_acc = 1, the value {acc_hi, acc_lo} is added to the product modulo 2^64. With mode_acc = 0, nothing is added.
- R6: res_hi carries bits 63:32 of the result and res_lo carries bits 31:0.
- R7: A start sampled high on clock edge k while idle makes done high for exactly one cycle, beginning at edge k+33 (32 iteration cycles plus one cycle to register the result). The result outputs change only at that edge.
- R8: When mode_flags was 1 at start, flag_vld pulses together with done. flag_z is 1 exactly when all 64 result bits are zero, and flag_n equals result bit 63.
- R9: When mode_flags was 0 at start, flag_vld stays 0 and flag_n and flag_z keep their previous values.
- R10: A start pulse while an operation is in progress is ignored. It changes neither the result nor the number of done pulses.
- R11: Between done pulses, res_hi and res_lo hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| instr_word | input | 32 | Instruction word to decode for indices |
| op_mcand | input | 32 | Multiplicand operand |
| op_mplier | input | 32 | Multiplier operand |
| acc_hi | input | 32 | Accumulator upper word |
| acc_lo | input | 32 | Accumulator lower word |
| mode_signed | input | 1 | 1: two's complement operands |
| mode_acc | input | 1 | 1: add accumulator to product |
| mode_flags | input | 1 | 1: update N/Z flags |
| idx_dst_hi | output | 4 | High destination index |
| idx_dst_lo | output | 4 | Low destination index |
| idx_mplier | output | 4 | Multiplier source index |
| idx_mcand | output | 4 | Multiplicand source index |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |
| flag_n | output | 1 | Negative flag (result bit 63) |
| flag_z | output | 1 | Zero flag over 64 bits |
| flag_vld | output | 1 | Flags updated this cycle |
| done | output | 1 | Result ready pulse |

## Verification
The assertions assume that start is a clean synchronous level. They also assume that every accepted start is followed by 33 cycles with no reset, because the latency check shadows the unit with a counter that starts only on starts sampled while it is idle.

The bench drives every input on the falling edge and lowers start after one cycle. When it tests the ignored-start case, it raises start deliberately in the middle of an operation and changes the operand inputs at the same time. That case shows that the captured values, and not the live inputs, decide the result.

// File: rtl/mac64_pkg.sv
package mac64_pkg;
    localparam int OPW    = 32;
    localparam int IDXW   = 4;
    localparam int NFIELD = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mac_state_e;

    // Field order: 0 dst high, 1 dst low, 2 multiplier, 3 multiplicand
    function automatic int field_lsb(input int f);
        case (f)
            0:       return 16;
            1:       return 12;
            2:       return 8;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/mac64_field_decode.sv
module mac64_field_decode
    import mac64_pkg::*;
#(
    parameter int WORDW = 32
) (
    input  logic [WORDW-1:0]             word_i,
    output logic [NFIELD-1:0][IDXW-1:0]  idx_o
);
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        localparam int LSB = field_lsb(f);
        assign idx_o[f] = word_i[LSB +: IDXW];
    end

    logic unused_bits;
    assign unused_bits = ^{word_i[WORDW-1:20], word_i[7:4]};
endmodule

// File: rtl/mac64_shift_add.sv
module mac64_shift_add #(
    parameter int OPW = 32,
    localparam int PRW = 2 * OPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic           neg_i,
    input  logic [PRW-1:0] init_acc_i,
    input  logic [PRW-1:0] mcand_ext_i,
    input  logic [OPW-1:0] mplier_i,
    output logic [PRW-1:0] acc_o
);
    typedef struct packed {
        logic [PRW-1:0] acc;
        logic [PRW-1:0] addend;
        logic [OPW-1:0] bits;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (load_i) begin
            dp_d.acc    = init_acc_i;
            dp_d.addend = mcand_ext_i;
            dp_d.bits   = mplier_i;
        end else if (step_i) begin
            if (dp_q.bits[0]) begin
                // Top multiplier bit has negative weight in signed mode
                dp_d.acc = neg_i ? (dp_q.acc - dp_q.addend)
                                 : (dp_q.acc + dp_q.addend);
            end
            dp_d.addend = dp_q.addend << 1;
            dp_d.bits   = dp_q.bits >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign acc_o = dp_q.acc;
endmodule

// File: rtl/mac64_flag_eval.sv
module mac64_flag_eval #(
    parameter int PRW = 64
) (
    input  logic [PRW-1:0] value_i,
    output logic           neg_o,
    output logic           zero_o
);
    assign neg_o  = value_i[PRW-1];
    assign zero_o = (value_i == '0);
endmodule

// File: rtl/mac64_unit.sv
module mac64_unit
    import mac64_pkg::*;
#(
    parameter int WORDW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WORDW-1:0] instr_word,
    input  logic [OPW-1:0]   op_mcand,
    input  logic [OPW-1:0]   op_mplier,
    input  logic [OPW-1:0]   acc_hi,
    input  logic [OPW-1:0]   acc_lo,
    input  logic             mode_signed,
    input  logic             mode_acc,
    input  logic             mode_flags,
    output logic [IDXW-1:0]  idx_dst_hi,
    output logic [IDXW-1:0]  idx_dst_lo,
    output logic [IDXW-1:0]  idx_mplier,
    output logic [IDXW-1:0]  idx_mcand,
    output logic [OPW-1:0]   res_hi,
    output logic [OPW-1:0]   res_lo,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_vld,
    output logic             done
);
    localparam int PRW = 2 * OPW;
    localparam int CW  = $clog2(OPW);

    typedef struct packed {
        mac_state_e     state;
        logic [CW-1:0]  cnt;
        logic           sgn;
        logic           sf;
        logic [PRW-1:0] res;
        logic           fn;
        logic           fz;
        logic           fv;
        logic           done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NFIELD-1:0][IDXW-1:0] idx_w;
    logic [PRW-1:0] acc_w;
    logic [PRW-1:0] init_acc_w;
    logic [PRW-1:0] mcand_ext_w;
    logic           load_w, step_w, last_w, neg_w;
    logic           fn_w, fz_w;

    mac64_field_decode #(.WORDW(WORDW)) u_decode (
        .word_i (instr_word),
        .idx_o  (idx_w)
    );

    assign idx_dst_hi = idx_w[0];
    assign idx_dst_lo = idx_w[1];
    assign idx_mplier = idx_w[2];
    assign idx_mcand  = idx_w[3];

    assign init_acc_w  = mode_acc ? {acc_hi, acc_lo} : '0;
    assign mcand_ext_w = {{OPW{mode_signed & op_mcand[OPW-1]}}, op_mcand};
    assign last_w      = (ctl_q.state == ST_RUN) && (ctl_q.cnt == CW'(OPW - 1));
    assign neg_w       = ctl_q.sgn & last_w;

    mac64_shift_add #(.OPW(OPW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_w),
        .step_i      (step_w),
        .neg_i       (neg_w),
        .init_acc_i  (init_acc_w),
        .mcand_ext_i (mcand_ext_w),
        .mplier_i    (op_mplier),
        .acc_o       (acc_w)
    );

    mac64_flag_eval #(.PRW(PRW)) u_flags (
        .value_i (acc_w),
        .neg_o   (fn_w),
        .zero_o  (fz_w)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.fv   = 1'b0;
        load_w     = 1'b0;
        step_w     = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    load_w      = 1'b1;
                    ctl_d.state = ST_RUN;
                    ctl_d.cnt   = '0;
                    ctl_d.sgn   = mode_signed;
                    ctl_d.sf    = mode_flags;
                end
            end
            ST_RUN: begin
                step_w = 1'b1;
                if (last_w) ctl_d.state = ST_FIN;
                else        ctl_d.cnt   = ctl_q.cnt + 1'b1;
            end
            ST_FIN: begin
                ctl_d.res   = acc_w;
                ctl_d.done  = 1'b1;
                ctl_d.state = ST_IDLE;
                if (ctl_q.sf) begin
                    ctl_d.fn = fn_w;
                    ctl_d.fz = fz_w;
                    ctl_d.fv = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign res_hi   = ctl_q.res[PRW-1:OPW];
    assign res_lo   = ctl_q.res[OPW-1:0];
    assign flag_n   = ctl_q.fn;
    assign flag_z   = ctl_q.fz;
    assign flag_vld = ctl_q.fv;
    assign done     = ctl_q.done;
endmodule

// File: rtl/mac64_unit_chk.sv
module mac64_unit_chk #(
    parameter int OPW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [OPW-1:0] res_hi,
    input logic [OPW-1:0] res_lo,
    input logic           flag_n,
    input logic           flag_z,
    input logic           flag_vld,
    input logic           done
);
    localparam int LAT = OPW + 1;
    localparam int SW  = $clog2(LAT + 1);

    logic [SW-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          shadow_q <= '0;
        else if (shadow_q == '0 && start)    shadow_q <= SW'(1);
        else if (shadow_q == SW'(LAT))       shadow_q <= '0;
        else if (shadow_q != '0)             shadow_q <= shadow_q + 1'b1;
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q == SW'(LAT)) |=> done);

    assert_no_extra_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(shadow_q == SW'(LAT)));

    assert_flag_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_vld |-> done);

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_vld |-> (flag_z == (res_hi == '0 && res_lo == '0)));

    assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_vld |-> (flag_n == res_hi[OPW-1]));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_vld |-> ($stable(flag_n) && $stable(flag_z)));

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_hi) && $stable(res_lo)));
endmodule

bind mac64_unit mac64_unit_chk #(.OPW(mac64_pkg::OPW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_vld (flag_vld),
    .done     (done)
);

// File: tb/tb_mac64_unit.sv
`timescale 1ns/1ps
module tb_mac64_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] op_mcand = '0, op_mplier = '0, acc_hi = '0, acc_lo = '0;
    logic        mode_signed = 1'b0, mode_acc = 1'b0, mode_flags = 1'b0;
    logic [3:0]  idx_dst_hi, idx_dst_lo, idx_mplier, idx_mcand;
    logic [31:0] res_hi, res_lo;
    logic        flag_n, flag_z, flag_vld, done;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_n = 1'b0, exp_z = 1'b0;

    always #10 clk = ~clk;

    mac64_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
        .op_mcand(op_mcand), .op_mplier(op_mplier), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .mode_signed(mode_signed), .mode_acc(mode_acc), .mode_flags(mode_flags),
        .idx_dst_hi(idx_dst_hi), .idx_dst_lo(idx_dst_lo), .idx_mplier(idx_mplier),
        .idx_mcand(idx_mcand), .res_hi(res_hi), .res_lo(res_lo), .flag_n(flag_n),
        .flag_z(flag_z), .flag_vld(flag_vld), .done(done)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FIL%s %s actual=%h expected=%h", "", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mac(input logic [31:0] a, input logic [31:0] b,
                                            input logic sg, input logic ac,
                                            input logic [31:0] hi, input logic [31:0] lo);
        logic [63:0] ea, eb, p;
        ea = sg ? {{32{a[31]}}, a} : {32'b0, a};
        eb = sg ? {{32{b[31]}}, b} : {32'b0, b};
        p  = ea * eb;
        if (ac) p = p + {hi, lo};
        return p;
    endfunction

    // Launch one operation and check latency, result and flags
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sg,
                          input logic ac, input logic sf, input logic [31:0] hi,
                          input logic [31:0] lo, input string req);
        logic [63:0] exp;
        int lat;
        exp = ref_mac(a, b, sg, ac, hi, lo);
        @(negedge clk);
        op_mcand = a; op_mplier = b; mode_signed = sg; mode_acc = ac;
        mode_flags = sf; acc_hi = hi; acc_lo = lo; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 33, "R7 latency", 64'(lat), 64'd33);
        chk({res_hi, res_lo} == exp, {req, " R6 result"}, {res_hi, res_lo}, exp);
        if (sf) begin
            exp_n = exp[63];
            exp_z = (exp == 64'd0);
        end
        chk(flag_vld == sf, sf ? "R8 flag_vld" : "R9 flag_vld", 64'(flag_vld), 64'(sf));
        chk({flag_n, flag_z} == {exp_n, exp_z}, sf ? "R8 flags" : "R9 flags held",
            64'({flag_n, flag_z}), 64'({exp_n, exp_z}));
        @(negedge clk);
        chk(done == 1'b0, "R7 single pulse", 64'(done), 64'd0);
    endtask

    task automatic test_reset();
        chk({res_hi, res_lo} == 64'd0, "R1 result", {res_hi, res_lo}, 64'd0);
        chk({flag_n, flag_z, flag_vld, done} == 4'd0, "R1 flags/done",
            64'({flag_n, flag_z, flag_vld, done}), 64'd0);
    endtask

    task automatic test_decode();
        logic [31:0] words [3];
        words[0] = 32'h000F_5A0C;
        words[1] = 32'hFFF3_A5F6;
        words[2] = 32'h1234_5678;
        for (int i = 0; i < 3; i++) begin
            instr_word = words[i];
            #1;
            chk({idx_dst_hi, idx_dst_lo, idx_mplier, idx_mcand} ==
                {words[i][19:16], words[i][15:12], words[i][11:8], words[i][3:0]},
                "R2 decode", 64'({idx_dst_hi, idx_dst_lo, idx_mplier, idx_mcand}),
                64'({words[i][19:16], words[i][15:12], words[i][11:8], words[i][3:0]}));
        end
    endtask

    task automatic test_busy_start();
        logic [63:0] exp;
        int dones;
        exp = ref_mac(32'd1000, 32'd3000, 1'b0, 1'b0, 32'd0, 32'd0);
        @(negedge clk);
        op_mcand = 32'd1000; op_mplier = 32'd3000; mode_signed = 0; mode_acc = 0;
        mode_flags = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        op_mcand = 32'hDEAD; op_mplier = 32'hBEEF; mode_signed = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int c = 0; c < 80; c++) begin
            if (done) begin
                dones++;
                chk({res_hi, res_lo} == exp, "R10 result", {res_hi, res_lo}, exp);
            end
            @(negedge clk);
        end
        chk(dones == 1, "R10 done count", 64'(dones), 64'd1);
    endtask

    task automatic test_hold();
        logic [63:0] snap;
        snap = {res_hi, res_lo};
        op_mcand = 32'h5555_5555; op_mplier = 32'h7777; acc_hi = 32'h1; acc_lo = 32'h2;
        repeat (6) @(negedge clk);
        chk({res_hi, res_lo} == snap, "R11 hold", {res_hi, res_lo}, snap);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_decode();
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, "R3 unsigned max");
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0, 0, 0, "R3 unsigned mix");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 1, 0, 0, "R4 signed -1*-1");
        run_op(32'h8000_0000, 32'h8000_0000, 1, 0, 1, 0, 0, "R4 signed min*min");
        run_op(32'hFFFF_FFFD, 32'd7, 1, 0, 1, 0, 0, "R4 signed negative");
        run_op(32'd1, 32'd1, 0, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 wrap to zero");
        run_op(32'hFFFF_FFFF, 32'd5, 1, 1, 0, 32'd0, 32'd10, "R5 signed acc");
        run_op(32'h0001_0000, 32'h0001_0000, 0, 1, 1, 32'h7, 32'h8000_0000, "R5 carry into hi");
        test_busy_start();
        test_hold();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule